// File: doc/BRIEF.md
# Receive Signal Detect Qualifier

This block decides when a dual-speed Ethernet receiver is looking at real line activity. It watches a strobe that fires once for each valid pulse the receive comparator reports, a speed selector, and, in 10 Mb/s operation, a strobe for each valid Manchester bit. From these it produces a registered signal-detect flag. Two further outputs follow that flag. One picks the comparator reference: the high squelch level while idle, the lower unsquelch level, roughly 40% down, once activity is detected. The other tells the clock recovery loop whether to track the received data or the local transmit clock.

Detection needs a pair of valid pulses close together in time, so a lone noise pulse is rejected. Release depends on the speed. At 100 Mb/s the flag drops after a long silence of `LOS_100_CYC` cycles with no pulse; the default corresponds to about 1.2 s at 125 MHz. At 10 Mb/s it drops as soon as Manchester bits stop arriving for `MAN_WIN_CYC` cycles. A change of speed always returns the block to the squelched, undetected state.

Top module: `sigdet_qual`

## Requirements
- R1: In the undetected state, a valid pulse sampled k cycles after a first valid pulse, with 1 <= k <= `QUAL_WIN`, sets `sig_det` to 1 at the clock edge that samples the second pulse. A single pulse never sets it.
- R2: A first pulse that is not followed by another within `QUAL_WIN` cycles is forgotten. A pulse at k = `QUAL_WIN`+1 does not assert `sig_det` and instead becomes a new first pulse.
- R3: With `speed_100`=1 and `sig_det`=1, every valid pulse restarts an inactivity count. `sig_det` falls at the edge exactly `LOS_100_CYC` cycles after the last restart, where the detecting edge counts as a restart.
- R4: With `speed_100`=0 and `sig_det`=1, only `man_bit_vld` restarts the count, and valid pulses alone do not hold detection. `sig_det` falls at the edge exactly `MAN_WIN_CYC` cycles after the last Manchester strobe or the detecting edge.
- R5: `thr_low` is 1, selecting the unsquelch level, exactly while `sig_det` is 1, and it returns to 0 on every deassertion in either speed.
- R6: `cdr_use_rx` is 1, meaning track the received signal, exactly while `sig_det` is 1. Otherwise it is 0, meaning follow the transmit clock.
- R7: At the edge that samples a new value of `speed_100`, the block goes to the undetected state. It also discards any pending first pulse, and a pulse sampled at that same edge is ignored.
- R8: While `rst_n` is 0, `sig_det`, `thr_low` and `cdr_use_rx` are all 0.
- R9: Pulses seen while detected leave no pending first pulse, so after a deassertion two fresh pulses are needed to detect again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pulse_vld | input | 1 | One-cycle strobe per valid received pulse |
| speed_100 | input | 1 | 1 = 100 Mb/s mode, 0 = 10 Mb/s mode |
| man_bit_vld | input | 1 | One-cycle strobe per valid Manchester bit (10 Mb/s) |
| sig_det | output | 1 | Signal detected |
| thr_low | output | 1 | 1 = unsquelch (lower) threshold, 0 = squelch threshold |
| cdr_use_rx | output | 1 | 1 = clock recovery follows received data, 0 = transmit clock |

## Verification
A stuck or mis-aged pending-pulse register shows up as `sig_det` rising one cycle early or late at the window edge. It can also rise on an isolated pulse, within `QUAL_WIN`+1 cycles of the pulse. An inactivity count that is off by one, or restarted by the wrong strobe for the current speed, moves the falling edge of `sig_det` by a cycle. It can also hold the flag indefinitely, which is visible within one timeout window. Since the threshold and reference selects are meant to mirror the flag, any divergence between them appears at the same edge, and a missed speed change leaves `sig_det` high on the following cycle.

// File: rtl/sdq_pkg.sv
package sdq_pkg;
  typedef enum logic {
    SDQ_SQUELCHED = 1'b0,
    SDQ_DETECTED  = 1'b1
  } sdq_state_e;
endpackage

// File: rtl/sdq_pulse_qual.sv
module sdq_pulse_qual #(
  parameter int QUAL_WIN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_vld,
  input  logic hold,
  output logic qualify
);
  localparam int AW = $clog2(QUAL_WIN + 1);
  localparam logic [AW-1:0] AGE_LAST = AW'(QUAL_WIN - 1);

  logic          armed_q, armed_d;
  logic [AW-1:0] age_q, age_d;
  logic          upd_en;

  assign qualify = pulse_vld & armed_q & ~hold;
  assign upd_en  = hold | pulse_vld | armed_q;

  always_comb begin
    armed_d = armed_q;
    age_d   = age_q;
    if (hold) begin
      armed_d = 1'b0;
      age_d   = '0;
    end else if (pulse_vld) begin
      armed_d = ~armed_q;
      age_d   = '0;
    end else if (armed_q) begin
      if (age_q == AGE_LAST) begin
        armed_d = 1'b0;
        age_d   = '0;
      end else begin
        age_d = age_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      age_q   <= '0;
    end else if (upd_en) begin
      armed_q <= armed_d;
      age_q   <= age_d;
    end
  end
endmodule

// File: rtl/sdq_act_timer.sv
module sdq_act_timer #(
  parameter int LOS_100_CYC = 150_000_000,
  parameter int MAN_WIN_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic speed_100,
  input  logic pulse_vld,
  input  logic man_bit_vld,
  output logic expire
);
  localparam int LIM_MAX = (LOS_100_CYC > MAN_WIN_CYC) ? LOS_100_CYC : MAN_WIN_CYC;
  localparam int TW = $clog2(LIM_MAX + 1);
  localparam logic [TW-1:0] LOS_LAST = TW'(LOS_100_CYC - 1);
  localparam logic [TW-1:0] MAN_LAST = TW'(MAN_WIN_CYC - 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          restart;
  logic          at_last;
  logic          cnt_en;

  assign restart = speed_100 ? pulse_vld : man_bit_vld;
  assign at_last = speed_100 ? (cnt_q == LOS_LAST) : (cnt_q == MAN_LAST);
  assign expire  = active & ~restart & at_last;
  assign cnt_en  = active | (cnt_q != '0);

  always_comb begin
    if (!active || restart || at_last) cnt_d = '0;
    else                               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sdq_ctrl.sv
module sdq_ctrl
  import sdq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic speed_100,
  input  logic qualify,
  input  logic expire,
  output logic mode_chg,
  output logic detected
);
  sdq_state_e state_q, state_d;
  logic       speed_q;

  assign mode_chg = speed_100 ^ speed_q;
  assign detected = (state_q == SDQ_DETECTED);

  always_comb begin
    state_d = state_q;
    if (mode_chg)
      state_d = SDQ_SQUELCHED;
    else if (state_q == SDQ_SQUELCHED && qualify)
      state_d = SDQ_DETECTED;
    else if (state_q == SDQ_DETECTED && expire)
      state_d = SDQ_SQUELCHED;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SDQ_SQUELCHED;
      speed_q <= 1'b0;
    end else begin
      state_q <= state_d;
      speed_q <= speed_100;
    end
  end
endmodule

// File: rtl/sigdet_qual.sv
module sigdet_qual #(
  parameter int QUAL_WIN    = 8,
  parameter int LOS_100_CYC = 150_000_000,
  parameter int MAN_WIN_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_vld,
  input  logic speed_100,
  input  logic man_bit_vld,
  output logic sig_det,
  output logic thr_low,
  output logic cdr_use_rx
);
  logic qualify;
  logic expire;
  logic mode_chg;
  logic detected;
  logic hold;

  assign hold = detected | mode_chg;

  sdq_pulse_qual #(.QUAL_WIN(QUAL_WIN)) u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .pulse_vld (pulse_vld),
    .hold      (hold),
    .qualify   (qualify)
  );

  sdq_act_timer #(.LOS_100_CYC(LOS_100_CYC), .MAN_WIN_CYC(MAN_WIN_CYC)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .active      (detected & ~mode_chg),
    .speed_100   (speed_100),
    .pulse_vld   (pulse_vld),
    .man_bit_vld (man_bit_vld),
    .expire      (expire)
  );

  sdq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .speed_100 (speed_100),
    .qualify   (qualify),
    .expire    (expire),
    .mode_chg  (mode_chg),
    .detected  (detected)
  );

  assign sig_det    = detected;
  assign thr_low    = detected;
  assign cdr_use_rx = detected;
endmodule

// File: rtl/sigdet_qual_chk.sv
module sigdet_qual_chk (
  input logic clk,
  input logic rst_n,
  input logic pulse_vld,
  input logic speed_100,
  input logic man_bit_vld,
  input logic sig_det,
  input logic thr_low,
  input logic cdr_use_rx
);
  AST_THR_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    thr_low == sig_det); // R5

  AST_CDR_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    cdr_use_rx == sig_det); // R6

  AST_RISE_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sig_det) |-> $past(pulse_vld)); // R1

  AST_MODE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (speed_100 != $past(speed_100)) |=> !sig_det); // R7

  AST_FAST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_det && speed_100 && pulse_vld && (speed_100 == $past(speed_100))) |=> sig_det); // R3

  AST_SLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_det && !speed_100 && man_bit_vld && (speed_100 == $past(speed_100))) |=> sig_det); // R4
endmodule

bind sigdet_qual sigdet_qual_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pulse_vld   (pulse_vld),
  .speed_100   (speed_100),
  .man_bit_vld (man_bit_vld),
  .sig_det     (sig_det),
  .thr_low     (thr_low),
  .cdr_use_rx  (cdr_use_rx)
);

// File: tb/sigdet_qual_bench.sv
`timescale 1ns/1ps
module sigdet_qual_bench;
  localparam int QW  = 4;
  localparam int LOS = 20;
  localparam int MW  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pulse_vld = 1'b0;
  logic speed_100 = 1'b1;
  logic man_bit_vld = 1'b0;
  logic sig_det, thr_low, cdr_use_rx;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct { bit exp; int req; } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  sigdet_qual #(.QUAL_WIN(QW), .LOS_100_CYC(LOS), .MAN_WIN_CYC(MW)) u_sigdet_qual (
    .clk(clk), .rst_n(rst_n), .pulse_vld(pulse_vld), .speed_100(speed_100),
    .man_bit_vld(man_bit_vld), .sig_det(sig_det), .thr_low(thr_low),
    .cdr_use_rx(cdr_use_rx)
  );

  task automatic step(input bit p, input bit m, input bit s, input bit e, input int req);
    exp_t it;
    @(negedge clk);
    pulse_vld = p; man_bit_vld = m; speed_100 = s;
    it.exp = e; it.req = req;
    sb_q.push_back(it);
  endtask

  // monitor: compare outputs 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (sb_q.size() > 0) begin
      exp_t it;
      it = sb_q.pop_front();
      checks++;
      if (sig_det !== it.exp) begin
        failures++;
        $display("FAIL R%0d sig_det actual=%b expected=%b t=%0t", it.req, sig_det, it.exp, $time);
      end
      checks++;
      if (thr_low !== it.exp) begin
        failures++;
        $display("FAIL R5 thr_low actual=%b expected=%b t=%0t", thr_low, it.exp, $time);
      end
      checks++;
      if (cdr_use_rx !== it.exp) begin
        failures++;
        $display("FAIL R6 cdr_use_rx actual=%b expected=%b t=%0t", cdr_use_rx, it.exp, $time);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if ({sig_det, thr_low, cdr_use_rx} !== 3'b000) begin
      failures++;
      $display("FAIL R8 reset outputs actual=%b expected=000", {sig_det, thr_low, cdr_use_rx});
    end
    rst_n = 1'b1;
    repeat (3) step(0, 0, 1, 0, 8);

    // R1: second pulse at k = QW detects
    step(1, 0, 1, 0, 1);
    for (int i = 0; i < QW - 1; i++) step(0, 0, 1, 0, 1);
    step(1, 0, 1, 1, 1);
    // R3: restart mid-way, then full timeout
    for (int i = 0; i < 10; i++) step(0, 0, 1, 1, 3);
    step(1, 0, 1, 1, 3);
    for (int i = 1; i < LOS; i++) step(0, 0, 1, 1, 3);
    step(0, 0, 1, 0, 3);

    // R2: second pulse at k = QW+1 rejected, becomes new first
    step(1, 0, 1, 0, 2);
    for (int i = 0; i < QW; i++) step(0, 0, 1, 0, 2);
    step(1, 0, 1, 0, 2);
    step(0, 0, 1, 0, 2);
    step(1, 0, 1, 1, 2);
    // pulses during detection, then timeout
    step(1, 0, 1, 1, 9);
    for (int i = 1; i < LOS; i++) step(0, 0, 1, 1, 3);
    step(0, 0, 1, 0, 3);

    // R9: single pulse after drop does not detect; k = 1 pair does
    step(1, 0, 1, 0, 9);
    for (int i = 0; i < QW + 1; i++) step(0, 0, 1, 0, 9);
    step(1, 0, 1, 0, 1);
    step(1, 0, 1, 1, 1);

    // R7: speed change drops detection
    step(0, 0, 0, 0, 7);
    step(0, 0, 0, 0, 7);
    // R7: pending pulse discarded and pulse at change edge ignored
    step(1, 0, 0, 0, 7);
    step(1, 0, 1, 0, 7);
    step(1, 0, 1, 0, 7);
    step(1, 0, 1, 1, 1);
    step(0, 0, 0, 0, 7);

    // R4: 10 Mb/s detection held by Manchester strobes
    step(1, 0, 0, 0, 1);
    step(1, 0, 0, 1, 1);
    for (int r = 0; r < 3; r++) begin
      step(0, 0, 0, 1, 4);
      step(0, 0, 0, 1, 4);
      step(0, 1, 0, 1, 4);
    end
    // R4: pulses alone do not hold it; drop MW cycles after last strobe
    for (int i = 1; i < MW; i++) step(1, 0, 0, 1, 4);
    step(1, 0, 0, 0, 4);
    step(0, 0, 0, 0, 4);
    step(0, 0, 0, 0, 4);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule